// File: doc/BRIEF.md
# Dual-Identity Bus Address Recognizer

This block decides whether an IEEE 488 device is addressed. The device owns two 5-bit identities, a major one and a minor one. Each identity can have its talker role, its listener role, or both switched off. A processor sets the block up through a small write port. That port has one register for the addressing mode and one register for the two identities. While the attention line is high, the block takes each strobed command byte that the controller broadcasts. From these bytes it keeps the listener addressed state, the talker addressed state and the primary-received flags. It publishes them in an 8-bit status word. A separate bit in that word tells which identity currently owns the addressing.

There are two fixed modes that need no controller, talk-only and listen-only. Both can also be enabled together, so that the device talks to itself. There are also three addressing schemes. In primary-primary mode, either identity is recognised by its primary address alone. In primary-secondary mode, identity 0 is the primary address and identity 1 is the expected secondary address; the device becomes addressed only when both arrive back to back. In pass-through mode, a primary match on either identity only raises a flag. Any following secondary byte is then handed to the processor to resolve.

Top module: `gpib_addr_top`

## Requirements
- R1: After reset, `status_o`, `addr0_o`, `addr1_o`, `lacs_o`, `tacs_o`, `sec_valid_o` and `sec_o` are all zero.
  - The layout of `status_o` is: bit 7 talk-only, bit 6 listen-only, bit 5 end flag, bit 4 listener primary received, bit 3 talker primary received, bit 2 listener addressed, bit 1 talker addressed, bit 0 minor identity selected.
- R2: Each of these mode-register values selects a fixed mode:
  - 0x80 selects talk-only, which sets status bits 7 and 1.
  - 0x40 selects listen-only, which sets status bits 6 and 2.
  - 0xC0 selects both at once.
  - In these fixed modes, and for any mode value that is not listed in R2, R4, R7 or R8, command bytes change no status bit.
- R3: A write with `wr_sel_i`=1 loads an identity register.
  - Data bit 7 chooses the identity: 0 for identity 0, 1 for identity 1.
  - Bit 6 disables the talker, bit 5 disables the listener, and bits 4..0 hold the address.
  - `addrN_o` reads back {talker disable, listener disable, address} one cycle after the write.
- R4: In mode 0x01 (primary-primary), a listen byte 0x20+A or a talk byte 0x40+A addresses the identity whose address is A, provided that role is enabled at that identity.
  - Status bit 0 then shows the addressed identity: 0 for major, 1 for minor.
  - A byte aimed at a disabled role does not address that identity.
- R5: The following bytes clear addressing:
  - 0x3F (unlisten) clears the listener addressed state.
  - 0x5F (untalk) clears the talker addressed state.
  - A talk byte for any address other than an enabled talker of this device also clears the talker addressed state.
- R6: Only one identity is addressed at a time.
  - In mode 0x01, addressing one identity drops both roles held by the other identity.
  - A listen byte that matches both identities addresses the major identity.
- R7: In mode 0x02 (primary-secondary), the primary address is identity 0.
  - A primary match only sets status bit 4 (listen) or bit 3 (talk).
  - If the next command byte is 0x60+B, where B is the address of identity 1, the armed role becomes addressed and the flag clears.
  - Any other command byte clears the flag and addresses nothing.
- R8: In mode 0x03 (pass-through), a primary match on either identity sets bit 4 or bit 3, and sets bit 0 to the matching identity.
  - While a flag is set, each secondary byte (0x60 to 0x7F) keeps the flag set.
  - Each such byte also pulses `sec_valid_o` for one cycle with `sec_o` equal to the byte's low 5 bits.
  - Status bits 2 and 1 stay 0 in this mode.
- R9: A data byte is a strobed byte with attention low.
  - While the device listens (addressed or listen-only), a data byte loads status bit 5 with `eoi_i`.
  - When the device does not listen, data bytes leave bit 5 unchanged.
- R10: `lacs_o` equals status bit 2 AND NOT `atn_i`, and `tacs_o` equals status bit 1 AND NOT `atn_i`. Both are combinational on `atn_i`.
- R11: A mode-register write (`wr_sel_i`=0) clears status bits 5..0, the pending secondary pulse and `sec_o`.
  - A command byte strobed in the same cycle as a mode-register write is discarded.
  - A command byte strobed in the same cycle as an identity write is decoded against the identity values held before that write.
- R12: Bytes take effect only when `cmd_valid_i` is high. Status changes on the clock edge that samples the byte and is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the mode register, 1 selects the identity register |
| wr_data_i | input | 8 | Register write data |
| cmd_valid_i | input | 1 | Bus byte strobe |
| atn_i | input | 1 | Attention line: high for command bytes, low for data bytes |
| cmd_i | input | 8 | Bus byte; bits 6..0 are decoded |
| eoi_i | input | 1 | End flag that accompanies a data byte |
| status_o | output | 8 | Address status word |
| addr0_o | output | 7 | Readback of identity 0 {talker disable, listener disable, address} |
| addr1_o | output | 7 | Readback of identity 1 |
| lacs_o | output | 1 | Listener active |
| tacs_o | output | 1 | Talker active |
| sec_valid_o | output | 1 | One-cycle pulse: a pass-through secondary address is available |
| sec_o | output | 5 | Last passed-through secondary address |

## Verification
Two pairs of functions can land in the same clock cycle. The first pair is a register write from the processor and a command byte from the bus. The second pair is a primary match and a secondary match on consecutive bytes, which must resolve against state that was armed only one edge earlier.

The bench provokes the first pair with two collisions:
- a mode-register write issued together with a matching talk byte; the byte must be dropped;
- an identity write issued together with a talk byte for the old address; the old address must still match.

A behavioural model predicts every cycle. The bench compares that prediction with each status bit, the readback registers and the pass-through outputs. Directed constant checks confirm the hand-computed status words at each step.

// File: rtl/gpib_addr_pkg.sv
package gpib_addr_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam int ID_W   = ADDR_W + 2;

  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_PP   = 2'd1,
    AM_PS   = 2'd2,
    AM_PT   = 2'd3
  } am_e;

  typedef struct packed {
    logic              dt;
    logic              dl;
    logic [ADDR_W-1:0] adr;
  } ident_t;

  typedef struct packed {
    logic              lm0;
    logic              lm1;
    logic              tm0;
    logic              tm1;
    logic              unl;
    logic              unt;
    logic              ota;
    logic              sec;
    logic [ADDR_W-1:0] low;
  } dec_t;

  localparam logic [BYTE_W-1:0] MODE_TON  = 8'h80;
  localparam logic [BYTE_W-1:0] MODE_LON  = 8'h40;
  localparam logic [BYTE_W-1:0] MODE_BOTH = 8'hC0;
endpackage

// File: rtl/gpib_cfg_regs.sv
module gpib_cfg_regs
  import gpib_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              mode_wr_o,
  output logic              ton_o,
  output logic              lon_o,
  output am_e               am_o,
  output ident_t            id0_o,
  output ident_t            id1_o
);
  logic [BYTE_W-1:0] mode_q;
  ident_t            id_q [2];

  assign mode_wr_o = wr_en_i && !wr_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (mode_wr_o) begin
      mode_q <= wr_data_i;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_id
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[g] <= '0;
      end else if (wr_en_i && wr_sel_i && (wr_data_i[BYTE_W-1] == 1'(g))) begin
        id_q[g] <= ident_t'(wr_data_i[ID_W-1:0]);
      end
    end
  end

  assign id0_o = id_q[0];
  assign id1_o = id_q[1];
  assign ton_o = (mode_q == MODE_TON) || (mode_q == MODE_BOTH);
  assign lon_o = (mode_q == MODE_LON) || (mode_q == MODE_BOTH);

  // only the low two bits carry an addressing scheme, all else is none
  always_comb begin
    if (mode_q[BYTE_W-1:2] == '0) am_o = am_e'(mode_q[1:0]);
    else                          am_o = AM_NONE;
  end
endmodule

// File: rtl/gpib_cmd_dec.sv
module gpib_cmd_dec
  import gpib_addr_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  input  am_e               am_i,
  input  ident_t            id0_i,
  input  ident_t            id1_i,
  output dec_t              dec_o
);
  logic [1:0]        grp;
  logic [ADDR_W-1:0] low;
  logic              all1, lsn, tlk, use1;

  assign grp  = cmd_i[6:5];
  assign low  = cmd_i[ADDR_W-1:0];
  assign all1 = &low;
  assign lsn  = (grp == 2'b01) && !all1;
  assign tlk  = (grp == 2'b10) && !all1;
  // identity 1 is a primary only in the two-primary schemes
  assign use1 = (am_i == AM_PP) || (am_i == AM_PT);

  always_comb begin
    dec_o     = '0;
    dec_o.low = low;
    dec_o.lm0 = lsn && !id0_i.dl && (low == id0_i.adr);
    dec_o.lm1 = lsn && use1 && !id1_i.dl && (low == id1_i.adr);
    dec_o.tm0 = tlk && !id0_i.dt && (low == id0_i.adr);
    dec_o.tm1 = tlk && use1 && !id1_i.dt && (low == id1_i.adr);
    dec_o.unl = (grp == 2'b01) && all1;
    dec_o.unt = (grp == 2'b10) && all1;
    dec_o.ota = tlk && !dec_o.tm0 && !dec_o.tm1;
    dec_o.sec = (grp == 2'b11);
  end
endmodule

// File: rtl/gpib_addr_fsm.sv
module gpib_addr_fsm
  import gpib_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cmd_stb_i,
  input  logic              dat_stb_i,
  input  logic              eoi_i,
  input  logic              lon_i,
  input  am_e               am_i,
  input  dec_t              dec_i,
  input  logic [ADDR_W-1:0] sec_adr_i,
  output logic              la_o,
  output logic              ta_o,
  output logic              lpas_o,
  output logic              tpas_o,
  output logic              mjmn_o,
  output logic              eoi_o,
  output logic              sec_valid_o,
  output logic [ADDR_W-1:0] sec_o
);
  logic la_q, ta_q, lp_q, tp_q, mj_q, eoi_q, sv_q;
  logic la_d, ta_d, lp_d, tp_d, mj_d, eoi_d, sv_d;
  logic [ADDR_W-1:0] sec_q, sec_d;
  logic k_l, k_t;

  assign k_l = !dec_i.lm0;
  assign k_t = !dec_i.tm0;

  always_comb begin
    la_d  = la_q;
    ta_d  = ta_q;
    lp_d  = lp_q;
    tp_d  = tp_q;
    mj_d  = mj_q;
    eoi_d = eoi_q;
    sv_d  = 1'b0;
    sec_d = sec_q;
    if (clr_i) begin
      la_d  = 1'b0;
      ta_d  = 1'b0;
      lp_d  = 1'b0;
      tp_d  = 1'b0;
      mj_d  = 1'b0;
      eoi_d = 1'b0;
      sec_d = '0;
    end else begin
      if (cmd_stb_i && (am_i != AM_NONE)) begin
        lp_d = 1'b0;
        tp_d = 1'b0;
        case (am_i)
          AM_PP: begin
            if (dec_i.lm0 || dec_i.lm1) begin
              la_d = 1'b1;
              if (mj_q != k_l) ta_d = 1'b0;
              mj_d = k_l;
            end
            if (dec_i.tm0 || dec_i.tm1) begin
              ta_d = 1'b1;
              if (mj_q != k_t) la_d = 1'b0;
              mj_d = k_t;
            end
          end
          AM_PS: begin
            lp_d = dec_i.lm0;
            tp_d = dec_i.tm0;
            if (dec_i.sec && (dec_i.low == sec_adr_i)) begin
              if (lp_q) la_d = 1'b1;
              if (tp_q) ta_d = 1'b1;
            end
          end
          AM_PT: begin
            if (dec_i.lm0 || dec_i.lm1) begin
              lp_d = 1'b1;
              mj_d = k_l;
            end
            if (dec_i.tm0 || dec_i.tm1) begin
              tp_d = 1'b1;
              mj_d = k_t;
            end
            if (dec_i.sec && (lp_q || tp_q)) begin
              sv_d  = 1'b1;
              sec_d = dec_i.low;
              lp_d  = lp_q;
              tp_d  = tp_q;
            end
          end
          default: ;
        endcase
        if (dec_i.unl) la_d = 1'b0;
        if (dec_i.unt || dec_i.ota) ta_d = 1'b0;
      end
      if (dat_stb_i && (la_q || lon_i)) eoi_d = eoi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      la_q  <= 1'b0;
      ta_q  <= 1'b0;
      lp_q  <= 1'b0;
      tp_q  <= 1'b0;
      mj_q  <= 1'b0;
      eoi_q <= 1'b0;
      sv_q  <= 1'b0;
      sec_q <= '0;
    end else begin
      la_q  <= la_d;
      ta_q  <= ta_d;
      lp_q  <= lp_d;
      tp_q  <= tp_d;
      mj_q  <= mj_d;
      eoi_q <= eoi_d;
      sv_q  <= sv_d;
      sec_q <= sec_d;
    end
  end

  assign la_o        = la_q;
  assign ta_o        = ta_q;
  assign lpas_o      = lp_q;
  assign tpas_o      = tp_q;
  assign mjmn_o      = mj_q;
  assign eoi_o       = eoi_q;
  assign sec_valid_o = sv_q;
  assign sec_o       = sec_q;

  // R5
  unl_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_i && (am_i != AM_NONE) && dec_i.unl) |=> !la_q);
  // R5
  unt_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_i && (am_i != AM_NONE) && dec_i.unt) |=> !ta_q);
  // R11
  mode_wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!la_q && !ta_q && !lp_q && !tp_q && !mj_q && !sv_q));
  // R7
  ps_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(la_q) && (am_i == AM_PS)) |-> $past(lp_q));
  // R8
  pt_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (am_i == AM_PT) |-> (!la_q && !ta_q));
  // R8
  sec_only_pt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sv_q |-> (am_i == AM_PT));
endmodule

// File: rtl/gpib_addr_top.sv
module gpib_addr_top
  import gpib_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [7:0]        wr_data_i,
  input  logic              cmd_valid_i,
  input  logic              atn_i,
  input  logic [7:0]        cmd_i,
  input  logic              eoi_i,
  output logic [7:0]        status_o,
  output logic [6:0]        addr0_o,
  output logic [6:0]        addr1_o,
  output logic              lacs_o,
  output logic              tacs_o,
  output logic              sec_valid_o,
  output logic [4:0]        sec_o
);
  logic   mode_wr, ton, lon;
  am_e    am;
  ident_t id0, id1;
  dec_t   dec;
  logic   la, ta, lpas, tpas, mjmn, eoi_f;
  logic   la_st, ta_st;

  gpib_cfg_regs i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mode_wr_o (mode_wr),
    .ton_o     (ton),
    .lon_o     (lon),
    .am_o      (am),
    .id0_o     (id0),
    .id1_o     (id1)
  );

  gpib_cmd_dec i_dec (
    .cmd_i (cmd_i),
    .am_i  (am),
    .id0_i (id0),
    .id1_i (id1),
    .dec_o (dec)
  );

  gpib_addr_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (mode_wr),
    .cmd_stb_i   (cmd_valid_i && atn_i),
    .dat_stb_i   (cmd_valid_i && !atn_i),
    .eoi_i       (eoi_i),
    .lon_i       (lon),
    .am_i        (am),
    .dec_i       (dec),
    .sec_adr_i   (id1.adr),
    .la_o        (la),
    .ta_o        (ta),
    .lpas_o      (lpas),
    .tpas_o      (tpas),
    .mjmn_o      (mjmn),
    .eoi_o       (eoi_f),
    .sec_valid_o (sec_valid_o),
    .sec_o       (sec_o)
  );

  assign la_st    = la || lon;
  assign ta_st    = ta || ton;
  assign status_o = {ton, lon, eoi_f, lpas, tpas, la_st, ta_st, mjmn};
  assign addr0_o  = id0;
  assign addr1_o  = id1;
  assign lacs_o   = la_st && !atn_i;
  assign tacs_o   = ta_st && !atn_i;

  // R2
  fixed_mode_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ton || lon) |-> (!la && !ta && !lpas && !tpas));
endmodule

// File: tb/test_gpib_addr_top.sv
module test_gpib_addr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, cmd_valid = 1'b0, atn = 1'b0, eoi = 1'b0;
  logic [7:0] wr_data = '0, cmd = '0;
  logic [7:0] status;
  logic [6:0] addr0, addr1;
  logic       lacs, tacs, sec_valid;
  logic [4:0] sec;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  gpib_addr_top i_gpib_addr_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cmd_valid_i(cmd_valid), .atn_i(atn), .cmd_i(cmd),
    .eoi_i(eoi), .status_o(status), .addr0_o(addr0), .addr1_o(addr1),
    .lacs_o(lacs), .tacs_o(tacs), .sec_valid_o(sec_valid), .sec_o(sec)
  );

  // behavioural reference model
  int m_mode, m_a0, m_a1, m_sec;
  bit m_la, m_ta, m_lp, m_tp, m_mj, m_eoi, m_sv;

  function automatic bit m_ton(); return m_mode == 'h80 || m_mode == 'hC0; endfunction
  function automatic bit m_lon(); return m_mode == 'h40 || m_mode == 'hC0; endfunction
  function automatic int m_am();
    if ((m_mode & 'hFC) == 0) return m_mode;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_a0 = 0; m_a1 = 0; m_sec = 0;
      m_la = 0; m_ta = 0; m_lp = 0; m_tp = 0; m_mj = 0; m_eoi = 0; m_sv = 0;
    end else if (wr_en && !wr_sel) begin
      m_mode = wr_data;
      m_la = 0; m_ta = 0; m_lp = 0; m_tp = 0; m_mj = 0; m_eoi = 0; m_sv = 0; m_sec = 0;
    end else begin
      int c, lo, grp, am, a0, a1;
      bit lsn, tlk, l0, l1, t0, t1, nlp, ntp, nla, nta, nmj, lis;
      a0 = m_a0; a1 = m_a1;
      lis = m_la || m_lon();
      if (wr_en && wr_sel) begin
        if (wr_data[7]) m_a1 = wr_data[6:0];
        else            m_a0 = wr_data[6:0];
      end
      m_sv = 0;
      am = m_am();
      if (cmd_valid && atn && am != 0) begin
        c = cmd[6:0]; lo = c % 32; grp = c / 32;
        lsn = grp == 1 && lo != 31;
        tlk = grp == 2 && lo != 31;
        l0 = lsn && ((a0 & 'h20) == 0) && lo == (a0 % 32);
        t0 = tlk && ((a0 & 'h40) == 0) && lo == (a0 % 32);
        l1 = lsn && am != 2 && ((a1 & 'h20) == 0) && lo == (a1 % 32);
        t1 = tlk && am != 2 && ((a1 & 'h40) == 0) && lo == (a1 % 32);
        nla = m_la; nta = m_ta; nmj = m_mj; nlp = 0; ntp = 0;
        if (am == 1) begin
          if (l0 || l1) begin nla = 1; if (m_mj != !l0) nta = 0; nmj = !l0; end
          if (t0 || t1) begin nta = 1; if (m_mj != !t0) nla = 0; nmj = !t0; end
        end else if (am == 2) begin
          nlp = l0; ntp = t0;
          if (grp == 3 && lo == (a1 % 32)) begin
            if (m_lp) nla = 1;
            if (m_tp) nta = 1;
          end
        end else begin
          if (l0 || l1) begin nlp = 1; nmj = !l0; end
          if (t0 || t1) begin ntp = 1; nmj = !t0; end
          if (grp == 3 && (m_lp || m_tp)) begin
            m_sv = 1; m_sec = lo; nlp = m_lp; ntp = m_tp;
          end
        end
        if (grp == 1 && lo == 31) nla = 0;
        if ((grp == 2 && lo == 31) || (tlk && !t0 && !t1)) nta = 0;
        m_la = nla; m_ta = nta; m_mj = nmj; m_lp = nlp; m_tp = ntp;
      end
      if (cmd_valid && !atn && lis) m_eoi = eoi;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h @%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic cmp_model();
    bit mla, mta;
    mla = m_la || m_lon(); mta = m_ta || m_ton();
    chk("R2 ton", status[7], m_ton());
    chk("R2 lon", status[6], m_lon());
    chk("R9 eoi", status[5], m_eoi);
    chk("R7 lpas", status[4], m_lp);
    chk("R7 tpas", status[3], m_tp);
    chk("R4 la", status[2], mla);
    chk("R4 ta", status[1], mta);
    chk("R6 mjmn", status[0], m_mj);
    chk("R3 addr0", addr0, m_a0);
    chk("R3 addr1", addr1, m_a1);
    chk("R10 lacs", lacs, mla && !atn);
    chk("R10 tacs", tacs, mta && !atn);
    chk("R8 sec_valid", sec_valid, m_sv);
    chk("R8 sec", sec, m_sec);
  endtask

  // one cycle: compare previous result, then drive new inputs
  task automatic step(bit we, bit ws, int wd, bit cv, bit at, int cb, bit eo);
    @(negedge clk);
    cmp_model();
    wr_en = we; wr_sel = ws; wr_data = 8'(wd);
    cmd_valid = cv; atn = at; cmd = 8'(cb); eoi = eo;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic wmode(int v); step(1, 0, v, 0, 1, 0, 0); idle(); endtask
  task automatic waddr(int v); step(1, 1, v, 0, 1, 0, 0); idle(); endtask
  task automatic bcmd(int v); step(0, 0, 0, 1, 1, v, 0); idle(); endtask
  task automatic bdat(bit e); step(0, 0, 0, 1, 0, 8'h55, e); idle(); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 addr0", addr0, 0);
    chk("R1 sec_valid", sec_valid, 0);
    rst_n = 1'b1;
    idle();

    waddr('h25);
    waddr('hC9);
    @(negedge clk); chk("R3 addr0 rd", addr0, 'h25); chk("R3 addr1 rd", addr1, 'h49);

    wmode('h01);
    bcmd('h25);
    @(negedge clk); chk("R4 disabled listener", status, 'h00);
    bcmd('h45);
    @(negedge clk); chk("R4 major talk", status, 'h02);
    bcmd('h29);
    @(negedge clk); chk("R6 minor listen drops talk", status, 'h05);
    step(0, 0, 0, 0, 1, 'h3F, 0); idle();
    @(negedge clk); chk("R12 no strobe", status, 'h05);
    bcmd('h3F);
    @(negedge clk); chk("R5 unlisten", status, 'h01);
    bcmd('h45);
    bcmd('h47);
    @(negedge clk); chk("R5 other talker", status, 'h00);
    bcmd('h45);
    bcmd('h5F);
    @(negedge clk); chk("R5 untalk", status, 'h00);

    bcmd('h29);
    step(0, 0, 0, 1, 0, 'h55, 1);
    @(negedge clk); chk("R10 lacs low atn", lacs, 1);
    idle();
    @(negedge clk); chk("R9 eoi set", status[5], 1);
    bcmd('h3F);
    bdat(0);
    @(negedge clk); chk("R9 eoi ignored", status[5], 1);

    wmode('h02);
    @(negedge clk); chk("R11 mode clears", status, 'h00);
    waddr('h05);
    waddr('h83);
    bcmd('h25);
    @(negedge clk); chk("R7 lpas armed", status, 'h10);
    bcmd('h63);
    @(negedge clk); chk("R7 secondary addresses", status, 'h04);
    bcmd('h45);
    @(negedge clk); chk("R7 tpas armed", status, 'h0C);
    bcmd('h64);
    @(negedge clk); chk("R7 wrong secondary", status, 'h04);
    bcmd('h45);
    bcmd('h3F);
    @(negedge clk); chk("R7 disarm", status, 'h00);

    wmode('h03);
    bcmd('h43);
    @(negedge clk); chk("R8 minor tpas", status, 'h09);
    step(0, 0, 0, 1, 1, 'h6A, 0);
    @(negedge clk); chk("R8 pulse", sec_valid, 1); chk("R8 sec", sec, 'h0A);
    idle();
    @(negedge clk); chk("R8 pulse ends", sec_valid, 0); chk("R8 status", status, 'h09);
    bcmd('h25);
    bcmd('h7F);
    @(negedge clk); chk("R8 major lpas", status, 'h10);

    wmode('h01);
    step(1, 0, 'h01, 1, 1, 'h45, 0); idle();
    @(negedge clk); chk("R11 collide mode", status, 'h00);
    step(1, 1, 'h0C, 1, 1, 'h45, 0); idle();
    @(negedge clk); chk("R11 collide addr", status, 'h02); chk("R11 new addr", addr0, 'h0C);

    wmode('h80);
    @(negedge clk); chk("R2 ton", status, 'h82);
    bcmd('h5F);
    @(negedge clk); chk("R2 ton ignores", status, 'h82);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); chk("R10 tacs", tacs, 1);
    wmode('h40);
    bdat(1);
    @(negedge clk); chk("R2 lon eoi", status, 'h64);
    wmode('hC0);
    @(negedge clk); chk("R2 both", status, 'hC6);
    wmode('h07);
    bcmd('h2C);
    @(negedge clk); chk("R2 bad mode", status, 'h00);
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule